// File: doc/BRIEF.md
# Programmable Third-Order Sinc Decimator

This block turns a one-bit oversampled stream from a delta-sigma modulator into decimated output words. Three cascaded integrators run at the input sample rate. Three cascaded comb stages run once per output period. The number of input samples per output word, N, is a 12-bit code split across two 8-bit configuration registers. The code may be changed at run time and must lie between 19 and 4000 inclusive.

The filter can be restarted in four ways: the active-low sync pin, a hold bit in the upper configuration register, a one-cycle channel-change request, or a write that changes the code. A restart clears every integrator, comb delay and counter. After the restart is released, the first word whose window lies wholly after the release is the only one reported as valid. That word arrives after exactly three output periods.

The latched filter sum is normalised by the leading zeros of the code. It is then coded as unipolar or offset-binary bipolar, and presented at a 24-bit or 16-bit length.

Top module: `sinc3_decim`

## Requirements
- R1: After reset the lower register reads 0x40 and the upper register reads 0x01, which gives a code of 320, bipolar coding and 16-bit length; word_valid is low.
- R2: Writing address 0 sets code[7:0]. Writing address 1 sets code[11:8] from bits 3:0, unipolar select from bit 7, 24-bit length from bit 6 and sync hold from bit 4. Bit 5 of address 1 always reads 0. cfg_rdata returns the register that cfg_addr selects.
- R3: Once settled, word_valid pulses for one cycle after every N accepted samples, where N is the code.
- R4: After a restart is released, no word is valid until the sample numbered 3N. The word completed by that sample is flagged valid in the following cycle.
- R5: While sync_n is low or the sync hold bit is 1, the filter stays cleared and no word is flagged.
- R6: A one-cycle chan_chg pulse restarts the filter, so the next valid word comes 3N samples later.
- R7: A write that changes the code restarts the filter under the new code.
- R8: For an input whose ones density is p/q, where q divides N, the settled sum S equals N*N*N*p/q. An all-ones input gives N cubed.
- R9: Unipolar coding (bit 7 = 1): with L the number of leading zeros of the 12-bit code, the 24-bit result is bits 35:12 of S shifted left by 3L. An all-zeros input gives 0.
- R10: Bipolar coding (bit 7 = 0): the result is (2S - N cubed) shifted left by 3L and arithmetically right by 13, plus 0x800000. A density of one half gives 0x800000.
- R11: With bit 6 = 1, data_out carries the full 24-bit result. With bit 6 = 0, data_out carries the upper 16 bits of the result in bits 15:0, and bits 23:16 are zero.
- R12: Cycles with mod_en low consume no sample and do not advance the decimation count.
- R13: The accumulators are 37 bits wide and wrap in two's complement, so a code of 4000 with an all-ones input gives S = 64,000,000,000 exactly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mod_bit | input | 1 | Modulator output bit |
| mod_en | input | 1 | Qualifies mod_bit as a sample this cycle |
| sync_n | input | 1 | Active-low filter hold and restart |
| chan_chg | input | 1 | One-cycle channel-change restart request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 1 | 0 selects the lower register, 1 the upper |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected configuration register |
| word_valid | output | 1 | One-cycle pulse when a settled word is latched |
| data_out | output | 24 | Formatted output word |

## Verification
On every cycle the assertions check the following. The decimation count stays below the programmed code. A valid pulse always follows an accepted sample. A restart of any kind, whether hold, pin, channel change or code change, suppresses the valid pulse in the next cycle. A write to the lower register shows up in the code.

Only the bench scenarios can show the rest: the exact sample at which the first settled word appears, the N-sample spacing of later words, and the arithmetic values of the sum and of the unipolar, bipolar and 16-bit coding. The bench shows these across a sweep of codes, several ones densities, stalls on mod_en and the largest legal code.

// File: rtl/sinc3_pkg.sv
package sinc3_pkg;
    localparam int CODE_W  = 12;
    localparam int REG_W   = 8;
    localparam int ACC_W   = 3 * CODE_W + 1;
    localparam int OUT_W   = 24;
    localparam int SHORT_W = 16;

    typedef logic [ACC_W-1:0]  acc_t;
    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic [REG_W-1:0] hi;
        logic [REG_W-1:0] lo;
    } cfg_st_t;

    typedef struct packed {
        acc_t       i1;
        acc_t       i2;
        acc_t       i3;
        acc_t       d1;
        acc_t       d2;
        acc_t       d3;
        code_t      cnt;
        logic [1:0] settle;
        acc_t       word;
        logic       valid;
    } core_st_t;
endpackage

// File: rtl/sinc3_cfg_regs.sv
module sinc3_cfg_regs
    import sinc3_pkg::*;
#(
    parameter logic [REG_W-1:0] HI_RST  = 8'h01,
    parameter logic [REG_W-1:0] LO_RST  = 8'h40,
    parameter logic [REG_W-1:0] HI_MASK = 8'hDF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             addr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output code_t            code,
    output logic             unipolar,
    output logic             wlen24,
    output logic             sync_hold,
    output logic             code_chg
);
    localparam int HI_CODE_W = CODE_W - REG_W;

    cfg_st_t st_d, st_q;
    code_t   code_d;

    always_comb begin
        st_d = st_q;
        if (we) begin
            if (addr) st_d.hi = wdata & HI_MASK;
            else      st_d.lo = wdata;
        end
        code_d   = {st_d.hi[HI_CODE_W-1:0], st_d.lo};
        code_chg = (code_d != code);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hi <= HI_RST;
            st_q.lo <= LO_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign code      = {st_q.hi[HI_CODE_W-1:0], st_q.lo};
    assign unipolar  = st_q.hi[7];
    assign wlen24    = st_q.hi[6];
    assign sync_hold = st_q.hi[4];
    assign rdata     = addr ? st_q.hi : st_q.lo;

    assert_low_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !addr) |=> (code[REG_W-1:0] == $past(wdata)));
endmodule

// File: rtl/sinc3_cic_core.sv
module sinc3_cic_core
    import sinc3_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  mod_bit,
    input  logic  mod_en,
    input  logic  restart,
    input  code_t code,
    output logic  word_valid,
    output acc_t  word
);
    localparam logic [1:0] SETTLED = 2'd2;

    core_st_t st_d, st_q;
    acc_t     i1n, i2n, i3n, c1, c2, c3;
    logic     last_sample;

    always_comb begin
        st_d        = st_q;
        st_d.valid  = 1'b0;
        i1n         = st_q.i1 + acc_t'(mod_bit);
        i2n         = st_q.i2 + i1n;
        i3n         = st_q.i3 + i2n;
        c1          = i3n - st_q.d1;
        c2          = c1 - st_q.d2;
        c3          = c2 - st_q.d3;
        last_sample = (st_q.cnt == code - code_t'(1));
        if (restart) begin
            st_d        = '0;
            st_d.word   = st_q.word;
        end else if (mod_en) begin
            st_d.i1 = i1n;
            st_d.i2 = i2n;
            st_d.i3 = i3n;
            if (last_sample) begin
                st_d.cnt = '0;
                st_d.d1  = i3n;
                st_d.d2  = c1;
                st_d.d3  = c2;
                if (st_q.settle == SETTLED) begin
                    st_d.valid = 1'b1;
                    st_d.word  = c3;
                end else begin
                    st_d.settle = st_q.settle + 2'd1;
                end
            end else begin
                st_d.cnt = st_q.cnt + code_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_valid = st_q.valid;
    assign word       = st_q.word;

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < code);
    assert_valid_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(mod_en));
    assert_restart_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !word_valid);
endmodule

// File: rtl/sinc3_out_fmt.sv
module sinc3_out_fmt
    import sinc3_pkg::*;
(
    input  acc_t             word,
    input  code_t            code,
    input  logic             unipolar,
    input  logic             wlen24,
    output logic [OUT_W-1:0] data
);
    localparam int FS_W   = 3 * CODE_W;
    localparam int LO_UNI = FS_W - OUT_W;
    localparam int LO_BIP = ACC_W - OUT_W;

    logic [7:0]       lz;
    logic [7:0]       sh;
    acc_t             cw, cube, bd;
    logic [OUT_W-1:0] r_uni, r_bip, r24;

    always_comb begin
        lz = 8'(CODE_W);
        for (int b = 0; b < CODE_W; b++) begin
            if (code[b]) lz = 8'(CODE_W - 1 - b);
        end
        sh    = lz * 8'd3;
        cw    = acc_t'(code);
        cube  = cw * cw * cw;
        bd    = (word << 1) - cube;
        r_uni = OUT_W'((word << sh) >> LO_UNI);
        r_bip = OUT_W'((bd << sh) >> LO_BIP);
        r_bip[OUT_W-1] = ~r_bip[OUT_W-1];
        r24   = unipolar ? r_uni : r_bip;
        data  = wlen24 ? r24 : OUT_W'(r24[OUT_W-1 -: SHORT_W]);
    end
endmodule

// File: rtl/sinc3_decim.sv
module sinc3_decim
    import sinc3_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mod_bit,
    input  logic             mod_en,
    input  logic             sync_n,
    input  logic             chan_chg,
    input  logic             cfg_we,
    input  logic             cfg_addr,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    output logic             word_valid,
    output logic [OUT_W-1:0] data_out
);
    code_t code;
    logic  unipolar, wlen24, sync_hold, code_chg, restart;
    acc_t  word;

    sinc3_cfg_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .rdata     (cfg_rdata),
        .code      (code),
        .unipolar  (unipolar),
        .wlen24    (wlen24),
        .sync_hold (sync_hold),
        .code_chg  (code_chg)
    );

    assign restart = !sync_n || sync_hold || chan_chg || code_chg;

    sinc3_cic_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .mod_bit    (mod_bit),
        .mod_en     (mod_en),
        .restart    (restart),
        .code       (code),
        .word_valid (word_valid),
        .word       (word)
    );

    sinc3_out_fmt u_fmt (
        .word     (word),
        .code     (code),
        .unipolar (unipolar),
        .wlen24   (wlen24),
        .data     (data_out)
    );

    assert_hold_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_n || sync_hold) |=> !word_valid);
    assert_chan_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chan_chg |=> !word_valid);
endmodule

// File: tb/sim_sinc3_decim.sv
module sim_sinc3_decim;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mod_bit = 1'b0, mod_en = 1'b0, sync_n = 1'b1, chan_chg = 1'b0;
    logic        cfg_we = 1'b0, cfg_addr = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        word_valid;
    logic [23:0] data_out;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    sinc3_decim u0 (.*);

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input bit a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic longint expf(input longint s, input int n, input bit uni, input bit w24);
        int lz = 12;
        longint r;
        for (int b = 0; b < 12; b++) if (n[b]) lz = 11 - b;
        if (uni) r = ((s <<< (3 * lz)) >>> 12) & 64'hFFFFFF;
        else     r = ((((2 * s - longint'(n) * n * n) <<< (3 * lz)) >>> 13) + 64'h800000) & 64'hFFFFFF;
        return w24 ? r : (r >> 8);
    endfunction

    task automatic setcfg(input int n, input bit uni, input bit w24);
        wr(1'b1, {uni, w24, 2'b00, 4'(n >> 8)});
        wr(1'b0, 8'(n));
    endtask

    // Streams 4N samples with ones density p/q; checks first settled word
    // at sample 3N, the next at 4N, exactly two pulses, and the word value.
    task automatic stream(input int n, input int p, input int q, input bit gap,
                          input bit uni, input bit w24, input bit do_sync, input string tag);
        int k = 0, first = -1, second = -1, pulses = 0, cyc = 0;
        longint d1 = -1, d2 = -1;
        longint s = longint'(n) * n * n * p / q;
        if (do_sync) begin
            sync_n = 1'b0; mod_en = 1'b0;
            @(posedge clk); @(negedge clk);
            sync_n = 1'b1;
        end
        while (k < 4 * n) begin
            mod_en  = !(gap && cyc[0]);
            mod_bit = (k % q) < p;
            @(posedge clk); @(negedge clk);
            if (mod_en) k++;
            cyc++;
            if (word_valid) begin
                pulses++;
                if (first < 0) begin first = k; d1 = data_out; end
                else begin second = k; d2 = data_out; end
            end
        end
        mod_en = 1'b0;
        chk({tag, " R4 first word sample"}, first, 3 * n);
        chk({tag, " R3 next word sample"}, second, 4 * n);
        chk({tag, " R3 pulse count"}, pulses, 2);
        chk({tag, " R8 value"}, d1, expf(s, n, uni, w24));
        chk({tag, " R8 repeat value"}, d2, expf(s, n, uni, w24));
    endtask

    task automatic quiet(input int cycles, input string tag);
        int pulses = 0;
        for (int c = 0; c < cycles; c++) begin
            mod_en = 1'b1; mod_bit = 1'b1;
            @(posedge clk); @(negedge clk);
            if (word_valid) pulses++;
        end
        mod_en = 1'b0;
        chk({tag, " no word while held"}, pulses, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++; total++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values
        cfg_addr = 1'b0; #1 chk("R1 lower reg", cfg_rdata, 8'h40);
        cfg_addr = 1'b1; #1 chk("R1 upper reg", cfg_rdata, 8'h01);
        chk("R1 word_valid", word_valid, 0);
        @(negedge clk);
        // R1: default code 320, bipolar 16-bit, density 3/8
        stream(320, 3, 8, 1'b0, 1'b0, 1'b0, 1'b1, "R1 default");
        // R2: field layout and reserved bit
        wr(1'b1, 8'hFF);
        cfg_addr = 1'b1; #1 chk("R2 upper readback bit5 zero", cfg_rdata, 8'hDF);
        wr(1'b0, 8'h14);
        cfg_addr = 1'b0; #1 chk("R2 lower readback", cfg_rdata, 8'h14);
        @(negedge clk);
        // R8 R9 R11: sweep of small codes, all ones, unipolar 24-bit
        for (int n = 19; n <= 34; n++) begin
            setcfg(n, 1'b1, 1'b1);
            stream(n, 1, 1, 1'b0, 1'b1, 1'b1, 1'b1, "R9 sweep");
        end
        // R10: bipolar 24-bit, density 1/4
        setcfg(20, 1'b0, 1'b1);
        stream(20, 1, 4, 1'b0, 1'b0, 1'b1, 1'b1, "R10 quarter");
        // R10 R11: density one half, bipolar 16-bit gives 0x8000
        setcfg(24, 1'b0, 1'b0);
        stream(24, 1, 2, 1'b0, 1'b0, 1'b0, 1'b1, "R11 half");
        chk("R11 mid-scale short", data_out, 24'h008000);
        // R9 R12: zero input, unipolar, with stalled cycles
        setcfg(40, 1'b1, 1'b1);
        stream(40, 0, 1, 1'b1, 1'b1, 1'b1, 1'b1, "R12 stall");
        chk("R9 zero input", data_out, 0);
        // R5: hold bit and sync pin
        wr(1'b1, 8'hD0);
        quiet(200, "R5 hold bit");
        wr(1'b1, 8'hC0);
        stream(40, 1, 2, 1'b0, 1'b1, 1'b1, 1'b0, "R5 after hold");
        sync_n = 1'b0;
        quiet(200, "R5 sync pin");
        sync_n = 1'b1;
        stream(40, 1, 1, 1'b0, 1'b1, 1'b1, 1'b0, "R5 after pin");
        // R6: channel change
        chan_chg = 1'b1;
        @(posedge clk); @(negedge clk);
        chan_chg = 1'b0;
        stream(40, 1, 4, 1'b0, 1'b1, 1'b1, 1'b0, "R6 channel");
        // R7: code change restarts
        wr(1'b0, 8'd28);
        stream(28, 1, 4, 1'b0, 1'b1, 1'b1, 1'b0, "R7 new code");
        // R13: largest code, full scale both codings
        setcfg(4000, 1'b1, 1'b1);
        stream(4000, 1, 1, 1'b0, 1'b1, 1'b1, 1'b1, "R13 ones");
        chk("R13 full scale", data_out, 15625000);
        setcfg(4000, 1'b0, 1'b1);
        stream(4000, 0, 1, 1'b0, 1'b0, 1'b1, 1'b1, "R13 zeros bipolar");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule